// File: doc/BRIEF.md
# Ring Node with Address Enumeration

This block is one node of a serial ring that links battery monitor modules. A controller drives the first node, each node drives the next, and the last node returns the stream to the controller. The line idles high. Each incoming bit is oversampled and settled by a majority vote, and the node sends the stream on with clean, full-length bit cells.

The ring gets its addresses from an enumeration frame. The controller sends it with address 0. Each node takes the received address plus one as its own address and forwards that incremented value, so the count that comes back to the controller equals the number of nodes.

A read frame collects measurements. Every node forwards the frames of the nodes before it. When a node has forwarded the frame of its immediate predecessor, it appends a frame with its own address and local measurement. The controller therefore receives one frame per node, in address order.

There are two forwarding modes. In cut-through mode each voted bit goes out at once. In store mode a whole frame is received and checked before it is sent.

Top module: `ring_node`

## Requirements
- R1: After reset the serial output `tx_o` is high (idle) and `err_cnt_o` is 0.
- R2: Each bit is decided over OSR = 5 consecutive input samples (one per clock) and is 1 when at least 3 of them are high. A single wrong sample inside any bit cell therefore leaves the frame contents unchanged.
- R3: A start is detected on a falling edge of the input and must be confirmed by the vote of its bit cell. A low pulse of 2 samples produces no output frame and no error count.
- R4: The frame is sent least significant bit first: a start bit 0, a 4-bit command, an 8-bit address, a 10-bit value and a stop bit 1. Each bit cell is 5 clocks long on both input and output.
- R5: An enumeration frame (command 1) is forwarded with its address plus one, including carry. The node takes that incremented value as its own address. This holds in both forwarding modes.
- R6: A read frame (command 2) is always forwarded. If its address is one below the node's own address, the node then sends a frame with command 2, its own address and the value of `meas_i`. Read frames with any other address produce no extra frame.
- R7: A frame with any other command, and any read frame that is not the trigger, leaves the node with every field unchanged.
- R8: With `pass_en_i` high and the node idle, the output start bit begins within 3 bit cells of the input start edge. With `pass_en_i` low, output begins only after the whole frame has been received, at least 24 bit cells after the input start edge.
- R9: A frame whose stop bit votes 0 increments `err_cnt_o` by one, saturating at its maximum. In store mode the frame is dropped. In cut-through mode its bits have already been sent, so the bad stop bit is forwarded as well.
- R10: Until the node has received an enumeration frame, no read frame causes it to append a frame of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one input sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial stream from the upstream node |
| pass_en_i | input | 1 | 1 = forward each bit as soon as it is voted, 0 = store whole frames first |
| meas_i | input | 10 | Local measurement placed in the node's own reply |
| tx_o | output | 1 | Re-timed serial stream to the downstream node |
| err_cnt_o | output | 8 | Saturating count of frames with a bad stop bit |

## Verification
The bench first decides when the node is allowed to reply. It sends read frames before enumeration, read frames whose address equals the node's own address, and frames whose address is one below it. A node that compared against the wrong address, or that answered before it had an address, would add extra frames or miss its reply.

The increment is checked with an address of 0x0F in cut-through mode. A serial adder that dropped the carry would forward 0x00 in place of 0x10.

Glitched samples in every bit, and a two-sample false start, probe the vote. A wrong threshold would corrupt the fields or create a phantom frame.

Forwarding latency is measured in both modes. It shows whether cut-through actually happens and whether store mode waits for the checked stop bit. Bad stop bits are sent in both modes, so a node that forwarded a broken frame in store mode, or failed to count it, is caught.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  parameter int CMD_W  = 4;
  parameter int ADDR_W = 8;
  parameter int VAL_W  = 10;

  localparam int PAY_W    = CMD_W + ADDR_W + VAL_W;
  localparam int FRM_BITS = PAY_W + 2;
  localparam int POS_W    = $clog2(FRM_BITS);
  // Line positions of the address field (position 0 is the start bit)
  localparam int ADDR_LO  = 1 + CMD_W;
  localparam int ADDR_HI  = CMD_W + ADDR_W;

  localparam logic [CMD_W-1:0] CMD_ENUM = CMD_W'(1);
  localparam logic [CMD_W-1:0] CMD_READ = CMD_W'(2);

  // Bit 0 is the first payload bit on the line
  typedef struct packed {
    logic [VAL_W-1:0]  val;
    logic [ADDR_W-1:0] addr;
    logic [CMD_W-1:0]  cmd;
  } frame_t;
endpackage

// File: rtl/node_rx.sv
module node_rx
  import ring_node_pkg::*;
#(
  parameter int OSR = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  output logic             bit_stb_o,
  output logic             bit_val_o,
  output logic [POS_W-1:0] bit_pos_o,
  output logic             frm_stb_o,
  output logic             frm_ok_o,
  output frame_t           frm_o
);
  localparam int SCNT_W   = $clog2(OSR);
  localparam int CNT_W    = $clog2(OSR + 1);
  localparam int VOTE_MIN = OSR / 2 + 1;

  logic              rx_m, rx_s, rx_d;
  logic              busy;
  logic [SCNT_W-1:0] scnt;
  logic [CNT_W-1:0]  ones, ones_nx;
  logic [POS_W-1:0]  pos;
  logic [PAY_W-1:0]  shr;
  logic              last, vote;

  always_comb begin
    last    = (scnt == SCNT_W'(OSR - 1));
    ones_nx = ones + CNT_W'(rx_s);
    vote    = (ones_nx >= CNT_W'(VOTE_MIN));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_m <= rx_i;
      rx_s <= rx_m;
      rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      scnt      <= '0;
      ones      <= '0;
      pos       <= '0;
      shr       <= '0;
      bit_stb_o <= 1'b0;
      bit_val_o <= 1'b1;
      bit_pos_o <= '0;
      frm_stb_o <= 1'b0;
      frm_ok_o  <= 1'b0;
    end else begin
      bit_stb_o <= 1'b0;
      frm_stb_o <= 1'b0;
      if (!busy) begin
        if (rx_d && !rx_s) begin
          busy <= 1'b1;
          scnt <= SCNT_W'(1);
          ones <= '0;
          pos  <= '0;
        end
      end else if (!last) begin
        scnt <= scnt + 1'b1;
        ones <= ones_nx;
      end else begin
        scnt <= '0;
        ones <= '0;
        pos  <= pos + 1'b1;
        if (pos == '0) begin
          if (vote) begin
            busy <= 1'b0;
          end else begin
            bit_stb_o <= 1'b1;
            bit_val_o <= 1'b0;
            bit_pos_o <= '0;
          end
        end else if (pos == POS_W'(FRM_BITS - 1)) begin
          busy      <= 1'b0;
          bit_stb_o <= 1'b1;
          bit_val_o <= vote;
          bit_pos_o <= pos;
          frm_stb_o <= 1'b1;
          frm_ok_o  <= vote;
        end else begin
          bit_stb_o          <= 1'b1;
          bit_val_o          <= vote;
          bit_pos_o          <= pos;
          shr[pos - 1'b1]    <= vote;
        end
      end
    end
  end

  assign frm_o = frame_t'(shr);
endmodule

// File: rtl/node_fifo.sv
module node_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[wr_ptr[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_i && !full_o) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i && !empty_o) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign full_o  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign empty_o = (wr_ptr == rd_ptr);
  assign dout_o  = mem[rd_ptr[AW-1:0]];
endmodule

// File: rtl/node_tx.sv
module node_tx
  import ring_node_pkg::*;
#(
  parameter int OSR = 5
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   fwd_stb_i,
  input  logic   fwd_bit_i,
  input  logic   frm_valid_i,
  input  frame_t frm_i,
  output logic   frm_pop_o,
  output logic   tx_o,
  output logic   idle_o,
  output logic   frm_busy_o
);
  localparam int SCNT_W = $clog2(OSR);

  typedef enum logic [1:0] {TX_IDLE, TX_CELL, TX_FRAME} tx_state_t;

  tx_state_t           state;
  logic [SCNT_W-1:0]   cnt;
  logic [FRM_BITS-2:0] shr;
  logic [POS_W-1:0]    nbit;
  logic                cell_end;

  assign cell_end   = (cnt == SCNT_W'(OSR - 1));
  assign frm_pop_o  = (state == TX_IDLE) && !fwd_stb_i && frm_valid_i;
  assign idle_o     = (state == TX_IDLE);
  assign frm_busy_o = (state == TX_FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      tx_o  <= 1'b1;
      cnt   <= '0;
      shr   <= '1;
      nbit  <= '0;
    end else if (fwd_stb_i) begin
      state <= TX_CELL;
      tx_o  <= fwd_bit_i;
      cnt   <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (frm_valid_i) begin
            state <= TX_FRAME;
            tx_o  <= 1'b0;
            shr   <= {1'b1, frm_i};
            cnt   <= '0;
            nbit  <= '0;
          end
        end
        TX_CELL: begin
          if (cell_end) begin
            state <= TX_IDLE;
            tx_o  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (!cell_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (nbit == POS_W'(FRM_BITS - 1)) begin
              state <= TX_IDLE;
              tx_o  <= 1'b1;
            end else begin
              tx_o <= shr[0];
              shr  <= {1'b1, shr[FRM_BITS-2:1]};
              nbit <= nbit + 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int OSR        = 5,
  parameter int FIFO_DEPTH = 4,
  parameter int ERR_W      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_i,
  input  logic             pass_en_i,
  input  logic [VAL_W-1:0] meas_i,
  output logic             tx_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic             bit_stb, bit_val, frm_stb, frm_ok;
  logic [POS_W-1:0] bit_pos;
  frame_t           frm;

  logic             tx_idle, tx_frame_busy, fifo_pop, fifo_full, fifo_empty;
  logic [PAY_W-1:0] fifo_dout;

  logic              cut_q, carry_q, own_pend, enum_done;
  logic [ADDR_W-1:0] node_addr;

  logic   cut_now, fwd_stb, fwd_bit, is_enum, in_addr;
  logic   push_up, own_go, fifo_push, trigger;
  frame_t up_mod, own_frm, push_frm;

  node_rx #(.OSR(OSR)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_i      (rx_i),
    .bit_stb_o (bit_stb),
    .bit_val_o (bit_val),
    .bit_pos_o (bit_pos),
    .frm_stb_o (frm_stb),
    .frm_ok_o  (frm_ok),
    .frm_o     (frm)
  );

  always_comb begin
    cut_now  = pass_en_i && tx_idle && fifo_empty && !own_pend;
    fwd_stb  = bit_stb && ((bit_pos == '0) ? cut_now : cut_q);
    is_enum  = (frm.cmd == CMD_ENUM);
    in_addr  = (bit_pos >= POS_W'(ADDR_LO)) && (bit_pos <= POS_W'(ADDR_HI));
    fwd_bit  = (is_enum && in_addr) ? (bit_val ^ carry_q) : bit_val;

    up_mod = frm;
    if (is_enum) up_mod.addr = frm.addr + 1'b1;

    own_frm.cmd  = CMD_READ;
    own_frm.addr = node_addr;
    own_frm.val  = meas_i;

    push_up   = frm_stb && frm_ok && !cut_q;
    own_go    = own_pend && !push_up && !fifo_full;
    fifo_push = push_up || own_go;
    push_frm  = push_up ? up_mod : own_frm;
    trigger   = frm_stb && frm_ok && (frm.cmd == CMD_READ) && enum_done &&
                (frm.addr == node_addr - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_q     <= 1'b0;
      carry_q   <= 1'b1;
      own_pend  <= 1'b0;
      enum_done <= 1'b0;
      node_addr <= '0;
      err_cnt_o <= '0;
    end else begin
      if (bit_stb && bit_pos == '0) begin
        cut_q   <= cut_now;
        carry_q <= 1'b1;
      end else if (bit_stb && in_addr) begin
        carry_q <= carry_q & bit_val;
      end
      if (frm_stb) cut_q <= 1'b0;
      if (frm_stb && !frm_ok && err_cnt_o != '1) err_cnt_o <= err_cnt_o + 1'b1;
      if (frm_stb && frm_ok && is_enum) begin
        node_addr <= frm.addr + 1'b1;
        enum_done <= 1'b1;
      end
      if (trigger) own_pend <= 1'b1;
      else if (own_go) own_pend <= 1'b0;
    end
  end

  node_fifo #(.W(PAY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (fifo_push),
    .din_i   (PAY_W'(push_frm)),
    .pop_i   (fifo_pop),
    .dout_o  (fifo_dout),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  node_tx #(.OSR(OSR)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .fwd_stb_i   (fwd_stb),
    .fwd_bit_i   (fwd_bit),
    .frm_valid_i (!fifo_empty),
    .frm_i       (frame_t'(fifo_dout)),
    .frm_pop_o   (fifo_pop),
    .tx_o        (tx_o),
    .idle_o      (tx_idle),
    .frm_busy_o  (tx_frame_busy)
  );
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk
  import ring_node_pkg::*;
#(
  parameter int ERR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_o,
  input logic [ERR_W-1:0]  err_cnt_o,
  input logic              rx_frm_stb,
  input logic              rx_frm_ok,
  input frame_t            rx_frm,
  input logic [ADDR_W-1:0] node_addr,
  input logic              fwd_stb,
  input logic              tx_frame_busy,
  input logic              fifo_push,
  input logic              fifo_full
);
  // R1: line idles high right after reset
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> tx_o);

  // R4: every output level lasts more than one clock
  p_cell_min_len_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_o != $past(tx_o)) |=> $stable(tx_o));

  // R5: the node address follows the received enumeration address plus one
  p_addr_from_enum_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_frm_stb && rx_frm_ok && rx_frm.cmd == CMD_ENUM)
      |=> node_addr == ADDR_W'($past(rx_frm.addr) + 1'b1));

  // R7: stored frames never overflow the queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    !(fifo_push && fifo_full));

  // R8: a forwarded bit never collides with a whole frame being sent
  p_no_collision_r8: assert property (@(posedge clk) disable iff (rst)
    fwd_stb |-> !tx_frame_busy);

  // R9: a bad stop bit increments the error count
  p_bad_stop_counts_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_frm_stb && !rx_frm_ok && err_cnt_o != '1)
      |=> err_cnt_o == ERR_W'($past(err_cnt_o) + 1'b1));
endmodule

bind ring_node ring_node_chk #(.ERR_W(ERR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_o          (tx_o),
  .err_cnt_o     (err_cnt_o),
  .rx_frm_stb    (frm_stb),
  .rx_frm_ok     (frm_ok),
  .rx_frm        (frm),
  .node_addr     (node_addr),
  .fwd_stb       (fwd_stb),
  .tx_frame_busy (tx_frame_busy),
  .fifo_push     (fifo_push),
  .fifo_full     (fifo_full)
);

// File: tb/sim_ring_node.sv
`timescale 1ns/1ps
module sim_ring_node;
  import ring_node_pkg::*;

  localparam int OSR  = 5;
  localparam int WAIT = 400;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             rx  = 1'b1;
  logic             pass = 1'b0;
  logic [VAL_W-1:0] meas = 10'h2C7;
  logic             tx;
  logic [7:0]       err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int send_t = 0;

  frame_t              cap_f    [64];
  logic                cap_stop [64];
  int                  cap_t    [64];
  int                  ncap = 0;
  logic [FRM_BITS-1:0] dbits;

  ring_node #(.OSR(OSR)) u0 (
    .clk       (clk),
    .rst       (rst),
    .rx_i      (rx),
    .pass_en_i (pass),
    .meas_i    (meas),
    .tx_o      (tx),
    .err_cnt_o (err)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  // Output decoder: independent of the design, samples mid-cell
  initial begin : decoder
    forever begin
      @(negedge clk);
      if (!rst && tx === 1'b0 && ncap < 64) begin
        cap_t[ncap] = cyc;
        repeat (2) @(negedge clk);
        for (int i = 0; i < FRM_BITS; i++) begin
          if (i > 0) repeat (OSR) @(negedge clk);
          dbits[i] = tx;
        end
        cap_f[ncap]    = frame_t'(dbits[PAY_W:1]);
        cap_stop[ncap] = dbits[FRM_BITS-1];
        ncap++;
        while (tx !== 1'b1) @(negedge clk);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_frame(input int idx, input logic [CMD_W-1:0] c,
                           input logic [ADDR_W-1:0] a, input logic [VAL_W-1:0] v,
                           input string req);
    int act, exp;
    exp = int'({c, a, v, 1'b1});
    act = int'({cap_f[idx].cmd, cap_f[idx].addr, cap_f[idx].val, cap_stop[idx]});
    check(act == exp, req, act, exp);
  endtask

  task automatic send(input logic [CMD_W-1:0] c, input logic [ADDR_W-1:0] a,
                      input logic [VAL_W-1:0] v, input logic stp, input bit gl);
    frame_t              f;
    logic [FRM_BITS-1:0] b;
    f.cmd = c;
    f.addr = a;
    f.val = v;
    b = {stp, f, 1'b0};
    for (int i = 0; i < FRM_BITS; i++) begin
      for (int s = 0; s < OSR; s++) begin
        @(negedge clk);
        if (i == 0 && s == 0) send_t = cyc;
        rx = b[i] ^ (gl && s == 3);
      end
    end
    @(negedge clk);
    rx = 1'b1;
  endtask

  task automatic settle();
    repeat (WAIT) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(tx === 1'b1, "R1 idle output", int'(tx), 1);
    check(err === 8'd0, "R1 error count", int'(err), 0);
  endtask

  task automatic t_pre_enum();
    int b0 = ncap;
    pass = 1'b0;
    send(CMD_READ, 8'd0, 10'h155, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R10 no reply before enumeration", ncap - b0, 1);
    chk_frame(b0, CMD_READ, 8'd0, 10'h155, "R4 R7 read forwarded");
  endtask

  task automatic t_enum_store();
    int b0 = ncap;
    send(CMD_ENUM, 8'd1, 10'h000, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R5 enum frame count", ncap - b0, 1);
    chk_frame(b0, CMD_ENUM, 8'd2, 10'h000, "R5 enum address incremented");
  endtask

  task automatic t_read_append();
    int b0 = ncap;
    send(CMD_READ, 8'd1, 10'h0AA, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 2, "R6 predecessor plus own frame", ncap - b0, 2);
    chk_frame(b0, CMD_READ, 8'd1, 10'h0AA, "R6 predecessor first");
    chk_frame(b0 + 1, CMD_READ, 8'd2, meas, "R6 own reply");
    b0 = ncap;
    send(CMD_READ, 8'd0, 10'h011, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R6 no reply to address 0", ncap - b0, 1);
    b0 = ncap;
    send(CMD_READ, 8'd2, 10'h012, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R6 no reply to own address", ncap - b0, 1);
    chk_frame(b0, CMD_READ, 8'd2, 10'h012, "R7 own-address read unchanged");
  endtask

  task automatic t_other_cmd();
    int b0 = ncap;
    send(4'h5, 8'h7E, 10'h3A5, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R7 other command count", ncap - b0, 1);
    chk_frame(b0, 4'h5, 8'h7E, 10'h3A5, "R7 other command unchanged");
  endtask

  task automatic t_glitch();
    int b0 = ncap;
    send(4'h9, 8'h5A, 10'h26B, 1'b1, 1'b1);
    settle();
    check(ncap - b0 == 1, "R2 glitched frame count", ncap - b0, 1);
    chk_frame(b0, 4'h9, 8'h5A, 10'h26B, "R2 vote removes glitches");
  endtask

  task automatic t_false_start();
    int b0 = ncap;
    int e0 = int'(err);
    @(negedge clk);
    rx = 1'b0;
    repeat (2) @(negedge clk);
    rx = 1'b1;
    settle();
    check(ncap == b0, "R3 short pulse makes no frame", ncap - b0, 0);
    check(int'(err) == e0, "R3 short pulse makes no error", int'(err), e0);
  endtask

  task automatic t_bad_stop_store();
    int b0 = ncap;
    int e0 = int'(err);
    pass = 1'b0;
    send(CMD_READ, 8'h33, 10'h001, 1'b0, 1'b0);
    settle();
    check(ncap == b0, "R9 store mode drops frame", ncap - b0, 0);
    check(int'(err) == e0 + 1, "R9 store mode error count", int'(err), e0 + 1);
  endtask

  task automatic t_store_latency();
    int b0 = ncap;
    pass = 1'b0;
    send(CMD_READ, 8'h40, 10'h111, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 1, "R8 store mode frame count", ncap - b0, 1);
    check(cap_t[b0] - send_t >= FRM_BITS * OSR, "R8 store mode latency",
          cap_t[b0] - send_t, FRM_BITS * OSR);
  endtask

  task automatic t_pass_mode();
    int b0 = ncap;
    pass = 1'b1;
    send(CMD_READ, 8'h40, 10'h111, 1'b1, 1'b0);
    settle();
    check(cap_t[b0] - send_t <= 3 * OSR, "R8 cut-through latency",
          cap_t[b0] - send_t, 3 * OSR);
    chk_frame(b0, CMD_READ, 8'h40, 10'h111, "R8 cut-through frame");
    b0 = ncap;
    send(CMD_ENUM, 8'h0F, 10'h0C3, 1'b1, 1'b0);
    settle();
    chk_frame(b0, CMD_ENUM, 8'h10, 10'h0C3, "R5 serial increment with carry");
    b0 = ncap;
    send(CMD_READ, 8'h0F, 10'h003, 1'b1, 1'b0);
    settle();
    check(ncap - b0 == 2, "R6 cut-through reply count", ncap - b0, 2);
    chk_frame(b0, CMD_READ, 8'h0F, 10'h003, "R6 cut-through predecessor");
    chk_frame(b0 + 1, CMD_READ, 8'h10, meas, "R6 cut-through own reply");
  endtask

  task automatic t_bad_stop_pass();
    int b0 = ncap;
    int e0 = int'(err);
    pass = 1'b1;
    send(CMD_READ, 8'h21, 10'h0F0, 1'b0, 1'b0);
    settle();
    check(int'(err) == e0 + 1, "R9 cut-through error count", int'(err), e0 + 1);
    check(ncap - b0 == 1 && cap_stop[b0] == 1'b0, "R9 bad stop forwarded",
          int'(cap_stop[b0]), 0);
  endtask

  initial begin
    t_reset();
    t_pre_enum();
    t_enum_store();
    t_read_append();
    t_other_cmd();
    t_glitch();
    t_false_start();
    t_bad_stop_store();
    t_store_latency();
    t_pass_mode();
    t_bad_stop_pass();
    summary();
    $finish;
  end
endmodule